// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the hardware steps a small 32-bit processor takes when it enters an exception. A request arrives with one of four causes: trap or break, non-maskable interrupt, bus fault, or external interrupt. The request also carries the current program counter, the delay-slot flag, the stack pointer and the special registers. These are the condition/status word, the vector table base, the kernel stack pointer and the core version. From these the block picks a vector and works out the return address. It builds the status field, swaps the stack if the core was in user mode and pushes the condition/status word up one level. Then it fetches the handler address from the vector table over a request/acknowledge read port.

When the read completes, the block pulses `done` for one cycle. In that cycle it presents the new program counter, the updated register values and one write enable for each saved register. The register file consumes these. A version value below a threshold selects the older entry flow. That flow skips the status field, the delay-slot rewind and the status rotation, and it cannot take bus faults.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_req`, `done`, `err_unhandled` and `err_recursive` are 0.
- R2: `req_kind` encodes 0 = trap/break, 1 = NMI, 2 = bus fault, 3 = external interrupt. The vector is `trap_vec`, 0, `fault_vec` or `irq_vec` respectively. The handler read address `mem_addr` is `vec_base + vector*4`, taken modulo 2^32.
- R3: For an NMI, `new_nrp` = PC with `nrp_we`=1 and `erp_we`=0. For every other cause, `erp_we`=1 and `nrp_we`=0. In the newer flow `new_erp` = PC minus the delay-slot flag; in the older flow it is the PC.
- R4: In the newer flow, `new_exs` holds the low 8 bits of the vector at bits [15:8], with all other bits zero, and `exs_we`=1. In the older flow `exs_we`=0.
- R5: In the newer flow `new_dslot` is 0. In the older flow it equals the incoming delay-slot flag.
- R6: If bit U_BIT (default 8) of the status word is set at entry, `new_usp` = SP with `usp_we`=1 and `new_sp` = kernel SP. Otherwise `usp_we`=0 and `new_sp` = SP.
- R7: An NMI first clears bit M_BIT (default 9) of the status word, in both flows. In the newer flow the result W then becomes ((W & 0xC0000000) | ((W<<12)>>2)) on 32 bits, with bits [9:0] forced to 0. In the older flow W is passed on unchanged.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `done` pulses exactly one cycle after the ack cycle, with `new_pc` equal to the `mem_rdata` captured at the ack.
- R9: `req_ready` is 0 from the cycle after a request is accepted until `done` has been presented, and it is 1 again in the cycle after `done`. Requests made while `req_ready` is 0 are not started.
- R10: When `cpu_ver` is below 32, the older flow is used. A bus-fault request in that flow pulses `err_unhandled` for one cycle, issues no read and leaves `req_ready` at 1.
- R11: A bus-fault request made while a bus-fault entry is in progress pulses `err_recursive` for one cycle and does not disturb the entry already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request |
| req_kind | input | 2 | Cause encoding (see R2) |
| cur_pc | input | 32 | Current program counter |
| cur_dslot | input | 1 | Delay-slot flag |
| cur_sp | input | 32 | Current stack pointer |
| cur_ccs | input | 32 | Condition/status word |
| vec_base | input | 32 | Vector table base |
| kern_sp | input | 32 | Kernel stack pointer |
| cpu_ver | input | 8 | Core version |
| trap_vec | input | 8 | Trap vector |
| fault_vec | input | 8 | Bus fault vector |
| irq_vec | input | 8 | Interrupt controller vector |
| req_ready | output | 1 | Block can accept a request |
| mem_req | output | 1 | Vector table read request |
| mem_addr | output | 32 | Vector table read address |
| mem_ack | input | 1 | Read acknowledge |
| mem_rdata | input | 32 | Read data (handler address) |
| done | output | 1 | Entry complete, outputs valid |
| new_pc | output | 32 | Handler address |
| new_sp | output | 32 | Stack pointer after entry |
| new_usp | output | 32 | Saved user stack pointer |
| usp_we | output | 1 | Write user SP |
| new_erp | output | 32 | Exception return address |
| erp_we | output | 1 | Write exception return |
| new_nrp | output | 32 | NMI return address |
| nrp_we | output | 1 | Write NMI return |
| new_exs | output | 32 | Exception status value |
| exs_we | output | 1 | Write exception status |
| new_ccs | output | 32 | Status word after entry |
| new_dslot | output | 1 | Delay-slot flag after entry |
| err_unhandled | output | 1 | Bus fault in older flow |
| err_recursive | output | 1 | Bus fault during bus fault entry |

## Verification
The bench builds the block with its default parameters: status bits U at 8 and M at 9, and an older-flow threshold of 32. With these, every combination of cause, flow, user-mode flag and delay-slot flag can be swept. Read latencies of zero to two wait cycles are mixed in, so the hold of the read request and the timing of `done` are checked at several distances from the ack. Separate sequences cover the older-flow bus fault and a nested bus fault made during a bus-fault entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 32;
  typedef enum logic [1:0] {
    EK_TRAP = 2'd0,
    EK_NMI  = 2'd1,
    EK_BUSF = 2'd2,
    EK_IRQ  = 2'd3
  } exc_kind_e;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/exc_vec_select.sv
module exc_vec_select #(
  parameter int VEC_W = 8
) (
  input  logic [1:0]       kind,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic [VEC_W-1:0] irq_vec,
  output logic [VEC_W-1:0] vec,
  output logic             is_nmi
);
  import exc_entry_pkg::*;
  always_comb begin
    is_nmi = 1'b0;
    unique case (exc_kind_e'(kind))
      EK_TRAP: vec = trap_vec;
      EK_NMI:  begin vec = '0; is_nmi = 1'b1; end
      EK_BUSF: vec = fault_vec;
      default: vec = irq_vec;
    endcase
  end
endmodule

// File: rtl/exc_ccs_rotate.sv
module exc_ccs_rotate #(
  parameter int M_BIT = 9
) (
  input  logic [exc_entry_pkg::XLEN-1:0] ccs_in,
  input  logic                           clr_m,
  input  logic                           legacy,
  output logic [exc_entry_pkg::XLEN-1:0] ccs_out
);
  import exc_entry_pkg::*;
  localparam logic [XLEN-1:0] TOP_KEEP = 32'hC000_0000;
  localparam logic [XLEN-1:0] LOW_CLR  = 32'h0000_03FF;
  logic [XLEN-1:0] m_cleared, pushed;
  always_comb begin
    m_cleared = ccs_in;
    if (clr_m) m_cleared[M_BIT] = 1'b0;
    pushed = ((m_cleared & TOP_KEEP) | ((m_cleared << 12) >> 2)) & ~LOW_CLR;
    ccs_out = legacy ? m_cleared : pushed;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int VEC_W      = 8,
  parameter int VER_W      = 8,
  parameter int LEGACY_VER = 32,
  parameter int U_BIT      = 8,
  parameter int M_BIT      = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [31:0]      cur_pc,
  input  logic             cur_dslot,
  input  logic [31:0]      cur_sp,
  input  logic [31:0]      cur_ccs,
  input  logic [31:0]      vec_base,
  input  logic [31:0]      kern_sp,
  input  logic [VER_W-1:0] cpu_ver,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic [VEC_W-1:0] irq_vec,
  output logic             req_ready,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             done,
  output logic [31:0]      new_pc,
  output logic [31:0]      new_sp,
  output logic [31:0]      new_usp,
  output logic             usp_we,
  output logic [31:0]      new_erp,
  output logic             erp_we,
  output logic [31:0]      new_nrp,
  output logic             nrp_we,
  output logic [31:0]      new_exs,
  output logic             exs_we,
  output logic [31:0]      new_ccs,
  output logic             new_dslot,
  output logic             err_unhandled,
  output logic             err_recursive
);
  import exc_entry_pkg::*;
  localparam int IDX_W = (VEC_W < 8) ? VEC_W : 8;

  seq_state_e      state;
  logic [1:0]      kind_q;
  logic            legacy_q;
  logic [VEC_W-1:0] vec;
  logic            is_nmi;
  logic [XLEN-1:0] ccs_next;
  logic            legacy;
  logic            accept;
  logic [31:0]     exs_val;
  logic [31:0]     vec_off;

  exc_vec_select #(.VEC_W(VEC_W)) u_vsel (
    .kind(req_kind), .trap_vec(trap_vec), .fault_vec(fault_vec),
    .irq_vec(irq_vec), .vec(vec), .is_nmi(is_nmi)
  );

  exc_ccs_rotate #(.M_BIT(M_BIT)) u_rot (
    .ccs_in(cur_ccs), .clr_m(is_nmi), .legacy(legacy), .ccs_out(ccs_next)
  );

  always_comb begin
    legacy  = (int'(cpu_ver) < LEGACY_VER);
    accept  = (state == ST_IDLE) && req_valid;
    exs_val = '0;
    exs_val[8 +: IDX_W] = vec[IDX_W-1:0];
    vec_off = 32'(vec) << 2;
  end

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; kind_q <= '0; legacy_q <= 1'b0;
      mem_req <= 1'b0; mem_addr <= '0; done <= 1'b0;
      new_pc <= '0; new_sp <= '0; new_usp <= '0; usp_we <= 1'b0;
      new_erp <= '0; erp_we <= 1'b0; new_nrp <= '0; nrp_we <= 1'b0;
      new_exs <= '0; exs_we <= 1'b0; new_ccs <= '0; new_dslot <= 1'b0;
      err_unhandled <= 1'b0; err_recursive <= 1'b0;
    end else begin
      done <= 1'b0;
      err_unhandled <= 1'b0;
      err_recursive <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (legacy && req_kind == EK_BUSF) begin
            err_unhandled <= 1'b1;
          end else begin
            state    <= ST_FETCH;
            kind_q   <= req_kind;
            legacy_q <= legacy;
            mem_req  <= 1'b1;
            mem_addr <= vec_base + vec_off;
            erp_we   <= !is_nmi;
            nrp_we   <= is_nmi;
            new_erp  <= cur_pc - {31'b0, cur_dslot & !legacy};
            new_nrp  <= cur_pc;
            new_exs  <= exs_val;
            exs_we   <= !legacy;
            new_dslot <= legacy ? cur_dslot : 1'b0;
            new_ccs  <= ccs_next;
            usp_we   <= cur_ccs[U_BIT];
            new_usp  <= cur_sp;
            new_sp   <= cur_ccs[U_BIT] ? kern_sp : cur_sp;
          end
        end
        ST_FETCH: if (mem_ack) begin
          mem_req <= 1'b0;
          new_pc  <= mem_rdata;
          done    <= 1'b1;
          state   <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
      if (state != ST_IDLE && req_valid && req_kind == EK_BUSF && kind_q == EK_BUSF)
        err_recursive <= 1'b1;
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> done);
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> req_ready);
  assert_user_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    done && !legacy_q |-> new_ccs[9:0] == 10'd0);
  assert_no_read_unhandled_R10: assert property (@(posedge clk) disable iff (rst)
    err_unhandled |-> !mem_req && req_ready);
endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic req_valid = 0; logic [1:0] req_kind = 0;
  logic [31:0] cur_pc = 0, cur_sp = 0, cur_ccs = 0, vec_base = 0, kern_sp = 0;
  logic cur_dslot = 0; logic [7:0] cpu_ver = 0, trap_vec = 0, fault_vec = 0, irq_vec = 0;
  logic mem_ack = 0; logic [31:0] mem_rdata = 0;
  logic req_ready, mem_req, done, usp_we, erp_we, nrp_we, exs_we, new_dslot;
  logic err_unhandled, err_recursive;
  logic [31:0] mem_addr, new_pc, new_sp, new_usp, new_erp, new_nrp, new_exs, new_ccs;

  exc_entry_seq dut (.*);

  int errs = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  function automatic logic [31:0] ccs_model(input logic [31:0] c, input bit nmi, input bit leg);
    logic [31:0] w = c;
    if (nmi) w[9] = 1'b0;
    if (leg) return w;
    return ((w & 32'hC000_0000) | ((w << 12) >> 2)) & 32'hFFFF_FC00;
  endfunction

  task automatic run_case(input int kind, input bit leg, input bit u, input bit ds, input int idx, input bit nest);
    logic [7:0] v; logic [31:0] addr, rd;
    @(negedge clk);
    req_kind = 2'(kind); cur_pc = 32'h1000_0040 + idx * 36; cur_dslot = ds;
    cur_sp = 32'h7FFF_0F00 - idx * 16; kern_sp = 32'h8000_2000 + idx * 8;
    cur_ccs = (32'h9ABC_DEF1 * (idx + 1)) | 32'h200; cur_ccs[8] = u;
    vec_base = (idx % 4 == 3) ? 32'hFFFF_FF00 : 32'h0000_4000 + idx * 256;
    cpu_ver = leg ? 8'd10 : 8'd40;
    trap_vec = 8'h10 + 8'(idx); fault_vec = 8'h80 + 8'(idx); irq_vec = 8'hF0 - 8'(idx);
    v = (kind == 0) ? trap_vec : (kind == 1) ? 8'h00 : (kind == 2) ? fault_vec : irq_vec;
    addr = vec_base + {22'b0, v, 2'b00};
    rd = addr ^ 32'h5A5A_0003;
    req_valid = 1;
    @(negedge clk); req_valid = 0;
    chk(mem_req === 1 && req_ready === 0, "R9 busy after accept", {30'b0, mem_req, req_ready}, 32'h2);
    chk(mem_addr === addr, "R2 vector read address", mem_addr, addr);
    if (nest) begin
      req_valid = 1; req_kind = 2'd2;
      @(negedge clk); req_valid = 0;
      chk(err_recursive === 1, "R11 recursive fault flag", {31'b0, err_recursive}, 1);
      chk(mem_req === 1 && mem_addr === addr, "R11 entry undisturbed", mem_addr, addr);
    end
    for (int d = 0; d < idx % 3; d++) begin
      @(negedge clk);
      chk(mem_req === 1 && mem_addr === addr, "R8 request held", mem_addr, addr);
    end
    mem_rdata = rd; mem_ack = 1;
    @(negedge clk); mem_ack = 0; mem_rdata = 0;
    chk(done === 1 && mem_req === 0, "R8 done after ack", {30'b0, done, mem_req}, 32'h2);
    chk(new_pc === rd, "R8 handler pc", new_pc, rd);
    if (kind == 1) begin
      chk(nrp_we === 1 && erp_we === 0 && new_nrp === cur_pc, "R3 nmi return", new_nrp, cur_pc);
    end else begin
      chk(erp_we === 1 && nrp_we === 0, "R3 erp write", {31'b0, erp_we}, 1);
      chk(new_erp === cur_pc - (leg ? 0 : 32'(ds)), "R3 return address", new_erp, cur_pc - (leg ? 0 : 32'(ds)));
    end
    chk(exs_we === !leg, "R4 exs write enable", {31'b0, exs_we}, {31'b0, !leg});
    if (!leg) chk(new_exs === {16'b0, v, 8'b0}, "R4 exs value", new_exs, {16'b0, v, 8'b0});
    chk(new_dslot === (leg ? ds : 1'b0), "R5 dslot", {31'b0, new_dslot}, {31'b0, leg ? ds : 1'b0});
    chk(usp_we === u, "R6 usp write", {31'b0, usp_we}, {31'b0, u});
    if (u) chk(new_usp === cur_sp, "R6 user sp saved", new_usp, cur_sp);
    chk(new_sp === (u ? kern_sp : cur_sp), "R6 new sp", new_sp, u ? kern_sp : cur_sp);
    chk(new_ccs === ccs_model(cur_ccs, kind == 1, leg), "R7 status word", new_ccs, ccs_model(cur_ccs, kind == 1, leg));
    @(negedge clk);
    chk(done === 0 && req_ready === 1, "R9 ready again", {30'b0, done, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(req_ready === 1 && mem_req === 0 && done === 0 && err_unhandled === 0 && err_recursive === 0,
        "R1 reset state", {27'b0, req_ready, mem_req, done, err_unhandled, err_recursive}, 32'h10);
    for (int leg = 0; leg < 2; leg++)
      for (int k = 0; k < 4; k++)
        for (int u = 0; u < 2; u++)
          for (int ds = 0; ds < 2; ds++) begin
            if (leg == 1 && k == 2) continue;
            run_case(k, leg[0], u[0], ds[0], leg * 16 + k * 4 + u * 2 + ds, 1'b0);
          end
    // R10: older-flow bus fault
    @(negedge clk);
    req_kind = 2'd2; cpu_ver = 8'd31; req_valid = 1;
    @(negedge clk); req_valid = 0;
    chk(err_unhandled === 1 && mem_req === 0 && req_ready === 1, "R10 unhandled fault",
        {29'b0, err_unhandled, mem_req, req_ready}, 32'h5);
    @(negedge clk);
    chk(err_unhandled === 0 && mem_req === 0, "R10 pulse ends", {30'b0, err_unhandled, mem_req}, 0);
    // R11: nested bus fault during newer-flow bus fault entry
    run_case(2, 1'b0, 1'b1, 1'b1, 5, 1'b1);
    @(negedge clk);
    chk(err_recursive === 0 && mem_req === 0, "R11 no new entry", {30'b0, err_recursive, mem_req}, 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1; errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule